// File: doc/BRIEF.md
# Wavefront Issue Scheduler with RAW Interleaving

This block decides, cycle by cycle, which resident wave feeds a SIMD array narrower than a wave. A wave of `WAVE_SIZE` work-items is pushed through `SIMD_LANES` lanes, so one instruction occupies the array for `WAVE_SIZE/SIMD_LANES` consecutive beats (four at the defaults). Each beat is tagged with its index and a one-hot lane-group select that names which quarter of the wave is in the array.

For each wave slot, the surrounding logic presents a valid flag, an instruction-ready flag and the two source tags and one destination tag of the wave's next instruction. These stay fixed until the scheduler starts that instruction, which it signals with `issue_start`. A small per-wave scoreboard remembers the destination of the last started instruction. It keeps the wave out of arbitration while a source of its next instruction would read that result before it is ready. Another eligible wave is chosen round-robin in the meantime, so two waves with dependent chains keep the array fully busy. An occupancy input caps how many wave slots count as resident. Cycles with nothing to issue are bubbles and are counted.

Top module: `wave_issue_sched`

## Requirements
- R1: While `rst_n` is low, `issue_valid` is 0, `bubble` is 1, `lane_grp` is 0 and `stall_count` is 0.
- R2: Every instruction issues as `BEATS` consecutive cycles of the same wave, with `issue_beat` counting 0,1,2,3. `lane_grp` has only bit `issue_beat` set, and no other wave's beat comes between them.
- R3: A wave w may start an instruction only when `wave_valid[w]` and `inst_ready[w]` are 1, w is resident, and its sources are free of hazard.
- R4: An instruction with a source tag equal to the destination tag of the same wave's previous instruction starts exactly `RAW_LAT` cycles after the previous instruction's last beat. A lone wave with such a chain shows a repeating pattern of 4 beats and 4 bubbles.
- R5: A wave whose next instruction does not read its previous destination issues back to back, with no bubble.
- R6: Two resident waves that each run a dependent chain alternate instruction by instruction with no bubble.
- R7: Among eligible waves, the scheduler picks the first one after the last issued wave in increasing index order, wrapping around. After reset the search starts at wave 0.
- R8: `bubble` is 1 in exactly the cycles with no beat issued, `lane_grp` is 0 then, and `stall_count` increases by one per bubble cycle, saturating at its maximum.
- R9: Wave slot w is resident only when w < `occ_limit`. A wave outside the limit never issues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_valid | input | NUM_WAVES | Wave slot holds a live wave |
| inst_ready | input | NUM_WAVES | Wave's next instruction is available |
| src_a_tags | input | NUM_WAVES*TAG_W | First source tag of each wave's next instruction |
| src_b_tags | input | NUM_WAVES*TAG_W | Second source tag of each wave's next instruction |
| dst_tags | input | NUM_WAVES*TAG_W | Destination tag of each wave's next instruction |
| occ_limit | input | $clog2(NUM_WAVES+1) | Number of resident wave slots, counted from slot 0 |
| issue_valid | output | 1 | A beat is in the array this cycle |
| issue_start | output | 1 | First beat of an instruction; the wave's inputs may advance |
| issue_wave | output | $clog2(NUM_WAVES) | Wave being issued |
| issue_beat | output | $clog2(BEATS) | Beat index within the instruction |
| lane_grp | output | BEATS | One-hot lane-group select |
| bubble | output | 1 | No beat issued this cycle |
| stall_count | output | CNT_W | Saturating count of bubble cycles |

## Verification
The assertions take a wave's valid, ready and tag inputs to describe its head instruction, held steady from the cycle the choice is made until `issue_start` shows the choice. The eligibility property compares a started wave against the inputs registered one edge earlier. The stimulus meets this by setting all wave inputs only while reset is held and keeping them constant for a whole scenario. Each scenario uses fixed tags, so every instruction of a chain is either dependent or independent. `occ_limit` never exceeds the number of slots.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Index visited k steps after base in a ring of n slots.
  function automatic int ring_step(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction

endpackage

// File: rtl/wsched_sb_entry.sv
module wsched_sb_entry #(
  parameter int TAG_W  = 6,
  parameter int HOLD   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [TAG_W-1:0] dst,
  input  logic [TAG_W-1:0] src_a,
  input  logic [TAG_W-1:0] src_b,
  output logic             hazard
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q;
  logic             busy;

  assign busy   = (cnt_q != '0);
  assign hazard = busy && ((src_a == tag_q) || (src_b == tag_q));

  always_comb begin
    cnt_d = cnt_q;
    if (set)       cnt_d = CW'(HOLD);
    else if (busy) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tag_q <= '0;
    else if (set) tag_q <= dst;
  end
endmodule

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb #(
  parameter int NUM_WAVES = 4,
  parameter int WID_W     = 2
) (
  input  logic [NUM_WAVES-1:0] req,
  input  logic [WID_W-1:0]     last,
  output logic                 gnt_valid,
  output logic [WID_W-1:0]     gnt_id
);
  import wsched_pkg::*;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_id    = '0;
    for (int k = 1; k <= NUM_WAVES; k++) begin
      if (!gnt_valid && req[ring_step(int'(last), k, NUM_WAVES)]) begin
        gnt_valid = 1'b1;
        gnt_id    = WID_W'(ring_step(int'(last), k, NUM_WAVES));
      end
    end
  end
endmodule

// File: rtl/wsched_beat_seq.sv
module wsched_beat_seq #(
  parameter int NUM_WAVES = 4,
  parameter int BEATS     = 4,
  parameter int WID_W     = 2,
  parameter int BEAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_valid,
  input  logic [WID_W-1:0]  pick_id,
  output logic              active,
  output logic [BEAT_W-1:0] beat,
  output logic [WID_W-1:0]  cur,
  output logic              take
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic              active_d;
  logic [BEAT_W-1:0] beat_d;
  logic              cur_en;

  assign take   = !active || (beat == LAST);
  assign cur_en = take && pick_valid;

  always_comb begin
    active_d = active;
    beat_d   = beat;
    if (take) begin
      active_d = pick_valid;
      beat_d   = '0;
    end else begin
      beat_d   = beat + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else begin
      active <= active_d;
      beat   <= beat_d;
    end
  end

  // Reset to the top slot so the first search begins at slot 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= WID_W'(NUM_WAVES - 1);
    else if (cur_en) cur <= pick_id;
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NUM_WAVES  = 4,
  parameter int TAG_W      = 6,
  parameter int WAVE_SIZE  = 64,
  parameter int SIMD_LANES = 16,
  parameter int RAW_LAT    = 4,
  parameter int CNT_W      = 16,
  localparam int BEATS     = WAVE_SIZE / SIMD_LANES,
  localparam int BEAT_W    = $clog2(BEATS),
  localparam int WID_W     = $clog2(NUM_WAVES),
  localparam int OCC_W     = $clog2(NUM_WAVES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WAVES-1:0]       wave_valid,
  input  logic [NUM_WAVES-1:0]       inst_ready,
  input  logic [NUM_WAVES*TAG_W-1:0] src_a_tags,
  input  logic [NUM_WAVES*TAG_W-1:0] src_b_tags,
  input  logic [NUM_WAVES*TAG_W-1:0] dst_tags,
  input  logic [OCC_W-1:0]           occ_limit,
  output logic                       issue_valid,
  output logic                       issue_start,
  output logic [WID_W-1:0]           issue_wave,
  output logic [BEAT_W-1:0]          issue_beat,
  output logic [BEATS-1:0]           lane_grp,
  output logic                       bubble,
  output logic [CNT_W-1:0]           stall_count
);
  // Hazard window counted from the cycle after the pick: the remaining
  // beats of the producer plus the fixed result latency.
  localparam int HOLD = BEATS - 1 + RAW_LAT;

  logic [NUM_WAVES-1:0] hazard;
  logic [NUM_WAVES-1:0] eligible;
  logic                 pick_valid;
  logic [WID_W-1:0]     pick_id;
  logic                 active;
  logic [BEAT_W-1:0]    beat;
  logic [WID_W-1:0]     cur;
  logic                 take;
  logic [CNT_W-1:0]     stall_d;
  logic                 stall_en;

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    localparam logic [OCC_W-1:0] SLOT = OCC_W'(w);
    logic set_w;

    assign set_w = take && pick_valid && (pick_id == WID_W'(w));

    wsched_sb_entry #(
      .TAG_W (TAG_W),
      .HOLD  (HOLD)
    ) u_sb (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (set_w),
      .dst    (dst_tags[w*TAG_W +: TAG_W]),
      .src_a  (src_a_tags[w*TAG_W +: TAG_W]),
      .src_b  (src_b_tags[w*TAG_W +: TAG_W]),
      .hazard (hazard[w])
    );

    assign eligible[w] = wave_valid[w] && inst_ready[w] &&
                         (SLOT < occ_limit) && !hazard[w];
  end

  wsched_rr_arb #(
    .NUM_WAVES (NUM_WAVES),
    .WID_W     (WID_W)
  ) u_arb (
    .req       (eligible),
    .last      (cur),
    .gnt_valid (pick_valid),
    .gnt_id    (pick_id)
  );

  wsched_beat_seq #(
    .NUM_WAVES (NUM_WAVES),
    .BEATS     (BEATS),
    .WID_W     (WID_W),
    .BEAT_W    (BEAT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_id    (pick_id),
    .active     (active),
    .beat       (beat),
    .cur        (cur),
    .take       (take)
  );

  assign issue_valid = active;
  assign issue_start = active && (beat == '0);
  assign issue_wave  = cur;
  assign issue_beat  = beat;
  assign bubble      = !active;

  always_comb begin
    lane_grp = '0;
    if (active) lane_grp[beat] = 1'b1;
  end

  assign stall_en = bubble && (stall_count != '1);
  assign stall_d  = stall_count + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stall_count <= '0;
    else if (stall_en) stall_count <= stall_d;
  end
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NUM_WAVES = 4,
  parameter int BEATS     = 4,
  parameter int CNT_W     = 16,
  parameter int WID_W     = 2,
  parameter int BEAT_W    = 2,
  parameter int OCC_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WAVES-1:0] wave_valid,
  input logic [NUM_WAVES-1:0] inst_ready,
  input logic [OCC_W-1:0]     occ_limit,
  input logic                 issue_valid,
  input logic                 issue_start,
  input logic [WID_W-1:0]     issue_wave,
  input logic [BEAT_W-1:0]    issue_beat,
  input logic [BEATS-1:0]     lane_grp,
  input logic                 bubble,
  input logic [CNT_W-1:0]     stall_count
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [NUM_WAVES-1:0] valid_q, ready_q;
  logic [OCC_W-1:0]     occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ready_q <= '0;
      occ_q   <= '0;
    end else begin
      valid_q <= wave_valid;
      ready_q <= inst_ready;
      occ_q   <= occ_limit;
    end
  end

  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_beat != LAST) |=> (issue_valid && issue_beat == $past(issue_beat) + BEAT_W'(1) && issue_wave == $past(issue_wave))); // R2

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_valid) |-> (issue_beat == '0)); // R2

  AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($countones(lane_grp) == 1 && lane_grp[issue_beat])); // R2

  AST_BUBBLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> (lane_grp == '0 && !issue_valid)); // R8

  AST_STALL_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble && stall_count != '1) |=> (stall_count == $past(stall_count) + CNT_W'(1))); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble |=> $stable(stall_count)); // R8

  AST_START_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_start |-> (valid_q[issue_wave] && ready_q[issue_wave])); // R3

  AST_START_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_start |-> (OCC_W'(issue_wave) < occ_q)); // R9
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_WAVES (NUM_WAVES),
  .BEATS     (BEATS),
  .CNT_W     (CNT_W),
  .WID_W     (WID_W),
  .BEAT_W    (BEAT_W),
  .OCC_W     (OCC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wave_valid  (wave_valid),
  .inst_ready  (inst_ready),
  .occ_limit   (occ_limit),
  .issue_valid (issue_valid),
  .issue_start (issue_start),
  .issue_wave  (issue_wave),
  .issue_beat  (issue_beat),
  .lane_grp    (lane_grp),
  .bubble      (bubble),
  .stall_count (stall_count)
);

// File: tb/wave_issue_sched_tb.sv
module wave_issue_sched_tb;
  localparam int NW    = 4;
  localparam int TW    = 6;
  localparam int CW    = 16;
  localparam int WIN   = 32;

  logic              clk;
  logic              rst_n;
  logic [NW-1:0]     wave_valid;
  logic [NW-1:0]     inst_ready;
  logic [NW*TW-1:0]  src_a_tags;
  logic [NW*TW-1:0]  src_b_tags;
  logic [NW*TW-1:0]  dst_tags;
  logic [2:0]        occ_limit;
  logic              issue_valid;
  logic              issue_start;
  logic [1:0]        issue_wave;
  logic [1:0]        issue_beat;
  logic [3:0]        lane_grp;
  logic              bubble;
  logic [CW-1:0]     stall_count;

  int checks = 0;
  int errors = 0;

  int obs_v [WIN];
  int obs_w [WIN];
  int obs_b [WIN];
  int obs_l [WIN];
  int sc_delta;

  wave_issue_sched u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wave_valid  (wave_valid),
    .inst_ready  (inst_ready),
    .src_a_tags  (src_a_tags),
    .src_b_tags  (src_b_tags),
    .dst_tags    (dst_tags),
    .occ_limit   (occ_limit),
    .issue_valid (issue_valid),
    .issue_start (issue_start),
    .issue_wave  (issue_wave),
    .issue_beat  (issue_beat),
    .lane_grp    (lane_grp),
    .bubble      (bubble),
    .stall_count (stall_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_wave(input int w, input bit v, input bit r,
                          input int sa, input int sb, input int d);
    wave_valid[w]            = v;
    inst_ready[w]            = r;
    src_a_tags[w*TW +: TW]   = TW'(sa);
    src_b_tags[w*TW +: TW]   = TW'(sb);
    dst_tags[w*TW +: TW]     = TW'(d);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    wave_valid = '0;
    inst_ready = '0;
    src_a_tags = '0;
    src_b_tags = '0;
    dst_tags   = '0;
    occ_limit  = 3'd4;
    repeat (2) @(negedge clk);
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Capture WIN cycles starting at the first instruction start.
  task automatic observe();
    int tries = 0;
    int sc0;
    while (!issue_start && tries < 100) begin
      @(negedge clk);
      tries++;
    end
    check(issue_start == 1'b1, "R3 start seen", int'(issue_start), 1);
    sc0 = int'(stall_count);
    for (int i = 0; i < WIN; i++) begin
      obs_v[i] = int'(issue_valid);
      obs_w[i] = int'(issue_wave);
      obs_b[i] = int'(issue_beat);
      obs_l[i] = int'(lane_grp);
      @(negedge clk);
    end
    sc_delta = int'(stall_count) - sc0;
  endtask

  // Compare the window with a pattern of period PER whose first 4 cycles
  // are beats; wave order given by wseq(instr index).
  task automatic match_pattern(input string req, input int per, input int nw_cycle,
                               input int first_w);
    int bad_v = -1, bad_b = -1, bad_w = -1, bad_l = -1;
    for (int i = 0; i < WIN; i++) begin
      int ph   = i % per;
      int ev   = (ph < 4) ? 1 : 0;
      int ew   = (first_w + (i / per)) % nw_cycle;
      if (nw_cycle == 1) ew = first_w;
      if (obs_v[i] != ev && bad_v < 0) bad_v = i;
      if (ev == 1 && obs_b[i] != ph && bad_b < 0) bad_b = i;
      if (ev == 1 && obs_w[i] != ew && bad_w < 0) bad_w = i;
      if (obs_l[i] != (ev == 1 ? (1 << ph) : 0) && bad_l < 0) bad_l = i;
    end
    check(bad_v < 0, {req, " valid/bubble pattern"}, bad_v < 0 ? 0 : obs_v[bad_v],
          bad_v < 0 ? 0 : (((bad_v % per) < 4) ? 1 : 0));
    check(bad_b < 0, "R2 beat index", bad_b < 0 ? 0 : obs_b[bad_b],
          bad_b < 0 ? 0 : bad_b % per);
    check(bad_w < 0, {req, " wave order"}, bad_w < 0 ? 0 : obs_w[bad_w],
          bad_w < 0 ? 0 : ((nw_cycle == 1) ? first_w : (first_w + bad_w / per) % nw_cycle));
    check(bad_l < 0, "R2 lane group", bad_l < 0 ? 0 : obs_l[bad_l],
          bad_l < 0 ? 0 : ((((bad_l % per) < 4)) ? (1 << (bad_l % per)) : 0));
  endtask

  task automatic t_reset();
    enter_reset();
    set_wave(0, 1'b1, 1'b1, 1, 2, 3);
    @(negedge clk);
    check(issue_valid == 1'b0, "R1 issue_valid", int'(issue_valid), 0);
    check(bubble == 1'b1, "R1 bubble", int'(bubble), 1);
    check(lane_grp == 4'd0, "R1 lane_grp", int'(lane_grp), 0);
    check(stall_count == '0, "R1 stall_count", int'(stall_count), 0);
  endtask

  // Lone wave with a dependent chain: 4 beats then 4 bubbles.
  task automatic t_single_dep();
    enter_reset();
    set_wave(0, 1'b1, 1'b1, 5, 0, 5);
    leave_reset();
    observe();
    match_pattern("R4", 8, 1, 0);
    check(sc_delta == WIN / 2, "R8 stall_count delta", sc_delta, WIN / 2);
  endtask

  // Independent chain on a wave reached through R3 filtering.
  task automatic t_ready_indep();
    enter_reset();
    set_wave(0, 1'b1, 1'b0, 1, 2, 3);
    set_wave(1, 1'b0, 1'b1, 1, 2, 3);
    set_wave(2, 1'b1, 1'b1, 1, 2, 3);
    leave_reset();
    observe();
    match_pattern("R5", 4, 1, 2);
    check(sc_delta == 0, "R5 no bubbles", sc_delta, 0);
  endtask

  task automatic t_two_dep();
    enter_reset();
    set_wave(0, 1'b1, 1'b1, 5, 5, 5);
    set_wave(1, 1'b1, 1'b1, 7, 0, 7);
    leave_reset();
    observe();
    match_pattern("R6", 4, 2, 0);
    check(sc_delta == 0, "R6 no bubbles", sc_delta, 0);
  endtask

  task automatic t_round_robin();
    enter_reset();
    for (int w = 0; w < NW; w++) set_wave(w, 1'b1, 1'b1, 1, 2, 3);
    leave_reset();
    observe();
    match_pattern("R7", 4, 4, 0);
  endtask

  // Only slot 0 resident: the second dependent wave cannot fill bubbles.
  task automatic t_occupancy();
    enter_reset();
    occ_limit = 3'd1;
    set_wave(0, 1'b1, 1'b1, 5, 0, 5);
    set_wave(1, 1'b1, 1'b1, 7, 0, 7);
    leave_reset();
    observe();
    match_pattern("R9", 8, 1, 0);
    check(sc_delta == WIN / 2, "R9 bubbles with limit 1", sc_delta, WIN / 2);
  endtask

  initial begin
    rst_n = 1'b0;
    wave_valid = '0;
    inst_ready = '0;
    src_a_tags = '0;
    src_b_tags = '0;
    dst_tags   = '0;
    occ_limit  = 3'd4;
    t_reset();
    t_single_dep();
    t_ready_indep();
    t_two_dep();
    t_round_robin();
    t_occupancy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule